// File: doc/BRIEF.md
# Temperature Sensor Two-Wire Slave Port

This block is the serial front end of a digital temperature sensor. It watches a two-wire SMBus/I2C style bus through its clock and data pins. The pins are sampled with the system clock. The block detects START and STOP conditions and answers only to its own 7-bit device address. A host uses the bus to do three things: write a register pointer, write a configuration byte, and read back either the latest temperature byte or the configuration byte. The slave pulls the data line low to acknowledge and to send zero bits. It never drives the line high.

The temperature value arrives on a plain parallel input with a one-cycle valid strobe. The block also holds the standby control. When the host sets the shutdown bit of the configuration byte, the conversion request output drops and the stored temperature stops following the input. The serial port keeps answering reads and writes throughout, so the host can read the frozen value and clear the bit again.

Top module: `tsens_smbus_slave`

## Requirements
- R1: After reset the data line is released (sda_oe_o = 0), conv_req_o is 1, and both the pointer and the configuration byte are 0x00, so the first read returns the temperature byte, which is 0x00.
- R2: The address byte carries the 7-bit address in its upper bits and the read/write flag in bit 0 (1 = read). The slave acknowledges only address 7'b1001101. For any other address it never pulls the line low until the next START or STOP.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START in any state, including in the middle of a byte, restarts address reception. A STOP returns the slave to idle with the line released.
- R4: Bytes travel MSB first in both directions. A read returns the register chosen by the pointer: 0x00 selects temperature and 0x01 selects configuration. Other pointer values read as 0x00.
- R5: In a write, the first data byte after the address loads the pointer. Every later byte of the same access is written to the configuration byte when the pointer is 0x01. Such bytes are ignored when the pointer is 0x00 (temperature is read-only).
- R6: The slave acknowledges every address and data byte it accepts by pulling SDA low through the ninth clock. It releases the line after that clock ends.
- R7: With the shutdown bit (bit 7 of the configuration byte) at 0, the stored temperature takes temp_i on every cycle in which temp_vld_i is 1.
- R8: With the shutdown bit at 1, conv_req_o is 0 and the stored temperature holds its value whatever temp_vld_i does. Bus reads and writes keep working.
- R9: While the slave transmits, a master ACK (SDA low on the ninth clock) makes it send the selected register again. A master NACK ends transmission, and the slave stays silent until STOP or START.
- R10: A repeated START after the pointer write, followed by a read address, returns the newly selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| temp_i | input | 8 | Latest conversion result |
| temp_vld_i | input | 1 | One-cycle strobe marking temp_i as new |
| conv_req_o | output | 1 | 1 while conversions are wanted (not in standby) |

## Verification
The bench aims at a START arriving four bits into a byte. A slave that does not reset its bit count there would take the wrong address and fail to acknowledge. It also sends a foreign address followed by a read. A slave that matched loosely, or that drove data without an address match, would pull the line low and corrupt the 0xFF the bench expects. Standby is tested by strobing a new temperature while the shutdown bit is set and clearing the bit afterwards. A design that froze only the request pin, or that stopped the bus as well, returns the new value or never acknowledges. A master ACK followed by a NACK, and a write of data to the read-only pointer, show whether the slave keeps or drops its transmitter at the right moment and whether it guards the temperature byte.

// File: rtl/tsens_pkg.sv
package tsens_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHDN_BIT = 7;
  localparam logic [BYTE_W-1:0] PTR_TEMP = 8'h00;
  localparam logic [BYTE_W-1:0] PTR_CFG  = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_HOLD
  } bus_state_e;

  // upper seven bits of the received address byte compared with our address
  function automatic logic addr_match(input logic [BYTE_W-1:0] rx,
                                      input logic [BYTE_W-2:0] own);
    return rx[BYTE_W-1:1] == own;
  endfunction

  // register chosen by the pointer for transmission
  function automatic logic [BYTE_W-1:0] read_select(input logic [BYTE_W-1:0] ptr,
                                                    input logic [BYTE_W-1:0] temp,
                                                    input logic [BYTE_W-1:0] cfg);
    logic [BYTE_W-1:0] r;
    case (ptr)
      PTR_TEMP: r = temp;
      PTR_CFG:  r = cfg;
      default:  r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tsens_line_sync.sv
module tsens_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tsens_reg_file.sv
module tsens_reg_file
  import tsens_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] temp_i,
  input  logic              temp_vld_i,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] temp_q,
  output logic              shdn,
  output logic              conv_req
);
  logic [BYTE_W-1:0] ptr_q, cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= PTR_TEMP;
      cfg_q  <= '0;
      temp_q <= '0;
    end else begin
      if (ptr_wr) ptr_q <= wr_byte;
      if (reg_wr && ptr_q == PTR_CFG) cfg_q <= wr_byte;
      if (temp_vld_i && !cfg_q[SHDN_BIT]) temp_q <= temp_i;
    end
  end

  assign shdn     = cfg_q[SHDN_BIT];
  assign conv_req = ~cfg_q[SHDN_BIT];
  assign rd_byte  = read_select(ptr_q, temp_q, cfg_q);
endmodule

// File: rtl/tsens_bus_fsm.sv
module tsens_bus_fsm
  import tsens_pkg::*;
#(
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'b1001101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              ptr_wr,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              addr_hit,
  output logic              addr_miss
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  bus_state_e        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, txsh;
  logic              rw_q, first_q, mnack_q;
  logic              byte_done, bus_evt;

  assign bus_evt   = start_ev | stop_ev;
  assign byte_done = scl_fall && (bitcnt == CNT_FULL) && !bus_evt;
  assign addr_hit  = byte_done && (state == ST_ADDR) && addr_match(shreg, DEV_ADDR);
  assign addr_miss = byte_done && (state == ST_ADDR) && !addr_match(shreg, DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      sda_oe  <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mnack_q <= 1'b0;
      ptr_wr  <= 1'b0;
      reg_wr  <= 1'b0;
      wr_byte <= '0;
    end else begin
      ptr_wr <= 1'b0;
      reg_wr <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && bitcnt < CNT_FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                sda_oe  <= 1'b1;
                state   <= ST_WR_ACK;
                wr_byte <= shreg;
                first_q <= 1'b0;
                if (first_q) ptr_wr <= 1'b1;
                else         reg_wr <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                state  <= ST_RD;
                txsh   <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
              end else begin
                state   <= ST_WR;
                first_q <= 1'b1;
                sda_oe  <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise && bitcnt < CNT_FULL) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RD_ACK;
              end else if (bitcnt != '0) begin
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txsh[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mnack_q <= sda_s;
            end else if (scl_fall) begin
              if (!mnack_q) begin
                state  <= ST_RD;
                txsh   <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
              end else begin
                state  <= ST_HOLD;
                sda_oe <= 1'b0;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsens_smbus_slave.sv
module tsens_smbus_slave
  import tsens_pkg::*;
#(
  parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'b1001101,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] temp_i,
  input  logic              temp_vld_i,
  output logic              conv_req_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic ptr_wr, reg_wr, addr_hit, addr_miss, shdn;
  logic [BYTE_W-1:0] wr_byte, rd_byte, temp_q;

  tsens_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tsens_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_byte(rd_byte), .sda_oe(sda_oe_o), .ptr_wr(ptr_wr), .reg_wr(reg_wr),
    .wr_byte(wr_byte), .addr_hit(addr_hit), .addr_miss(addr_miss)
  );

  tsens_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .reg_wr(reg_wr),
    .wr_byte(wr_byte), .temp_i(temp_i), .temp_vld_i(temp_vld_i),
    .rd_byte(rd_byte), .temp_q(temp_q), .shdn(shdn), .conv_req(conv_req_o)
  );
endmodule

// File: rtl/tsens_smbus_checker.sv
module tsens_smbus_checker
  import tsens_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              addr_hit,
  input logic              addr_miss,
  input logic              sda_oe,
  input logic              shdn,
  input logic              temp_vld,
  input logic [BYTE_W-1:0] temp_in,
  input logic [BYTE_W-1:0] temp_q
);
  assert_ack_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> sda_oe);
  assert_silent_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);
  assert_start_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
  assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn && temp_vld) |=> temp_q == $past(temp_in));
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn && temp_vld) |=> $stable(temp_q));
endmodule

bind tsens_smbus_slave tsens_smbus_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
  .addr_hit(addr_hit), .addr_miss(addr_miss), .sda_oe(sda_oe_o),
  .shdn(shdn), .temp_vld(temp_vld_i), .temp_in(temp_i), .temp_q(temp_q)
);

// File: tb/tsens_smbus_slave_bench.sv
`timescale 1ns/1ps
module tsens_smbus_slave_bench;
  localparam int HP = 10;
  localparam logic [6:0] ADDR = 7'b1001101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] temp_i = 8'h00;
  logic temp_vld_i = 1'b0;
  logic sda_oe_o, conv_req_o;
  wire  sda_line = sda_m & ~sda_oe_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit bus_idle = 1'b0;
  logic [7:0] model_temp = 8'h00, model_cfg = 8'h00;

  always #5 clk = ~clk;

  tsens_smbus_slave u_tsens_smbus_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .temp_i(temp_i), .temp_vld_i(temp_vld_i),
    .conv_req_o(conv_req_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison while the bus is idle (R8, R1)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && bus_idle) begin
      n_chk++;
      if (conv_req_o !== ~model_cfg[7] || sda_oe_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R8 idle compare actual=%b%b expected=%b0",
                 conv_req_o, sda_oe_o, ~model_cfg[7]);
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic phase(); repeat (HP) @(negedge clk); endtask

  task automatic bus_start();
    bus_idle = 1'b0;
    sda_m = 1'b1; phase(); scl_m = 1'b1; phase();
    sda_m = 1'b0; phase(); scl_m = 1'b0; phase();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; phase(); scl_m = 1'b1; phase(); sda_m = 1'b1; phase();
    bus_idle = 1'b1;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; phase(); scl_m = 1'b1; phase(); scl_m = 1'b0; phase();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; phase(); scl_m = 1'b1; phase(); b = sda_line;
    scl_m = 1'b0; phase();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = (b == 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  // R5 R6: pointer write plus optional data byte, every byte acknowledged
  task automatic wr_reg(input logic [7:0] ptr, input logic [7:0] data, input bit with_data);
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, "R6 addr ack", a, 1);
    send_byte(ptr, a);          check(a, "R6 ptr ack", a, 1);
    check(sda_oe_o == 1'b0, "R6 release after ack", sda_oe_o, 0);
    if (with_data) begin
      send_byte(data, a);       check(a, "R6 data ack", a, 1);
    end
    bus_stop();
    if (with_data && ptr == 8'h01) model_cfg = data;
  endtask

  // R10: pointer write, repeated START, read one byte with NACK
  task automatic rd_reg(input logic [7:0] ptr, output logic [7:0] v);
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, "R2 addr ack", a, 1);
    send_byte(ptr, a);          check(a, "R6 ptr ack", a, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, a); check(a, "R10 read addr ack", a, 1);
    recv_byte(v, 1'b0);
    bus_stop();
  endtask

  task automatic pulse_temp(input logic [7:0] v);
    temp_i = v; temp_vld_i = 1'b1; @(negedge clk);
    temp_vld_i = 1'b0; @(negedge clk);
    if (!model_cfg[7]) model_temp = v;
  endtask

  initial begin
    logic [7:0] v, v2;
    bit a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_idle = 1'b1;

    // R1 reset state
    check(sda_oe_o == 1'b0, "R1 sda released", sda_oe_o, 0);
    check(conv_req_o == 1'b1, "R1 conv_req", conv_req_o, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, a); check(a, "R1 addr ack", a, 1);
    recv_byte(v, 1'b0); bus_stop();
    check(v == 8'h00, "R1 temp after reset", v, 0);
    rd_reg(8'h01, v); check(v == 8'h00, "R1 cfg after reset", v, 0);

    // R7 R4 capture and MSB-first read
    pulse_temp(8'hA3);
    rd_reg(8'h00, v); check(v == model_temp, "R4 R7 temp read", v, model_temp);
    pulse_temp(8'h5C);
    rd_reg(8'h00, v); check(v == model_temp, "R7 temp read", v, model_temp);

    // R5 config write and readback, write to temp ignored, unknown pointer
    wr_reg(8'h01, 8'h5A, 1'b1);
    rd_reg(8'h01, v); check(v == 8'h5A, "R5 cfg readback", v, 8'h5A);
    wr_reg(8'h00, 8'h77, 1'b1);
    rd_reg(8'h00, v); check(v == model_temp, "R5 temp read-only", v, model_temp);
    rd_reg(8'h05, v); check(v == 8'h00, "R4 unknown ptr", v, 0);

    // R2 foreign address: no ack, no drive
    bus_start();
    send_byte({7'b1001100, 1'b1}, a); check(!a, "R2 foreign addr nack", a, 0);
    recv_byte(v, 1'b0); check(v == 8'hFF, "R2 silent on miss", v, 8'hFF);
    bus_stop();

    // R3 START mid-byte restarts address reception
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, "R3 addr after mid-byte start", a, 1);
    send_byte(8'h01, a); send_byte(8'h33, a); check(a, "R3 data ack", a, 1);
    bus_stop(); model_cfg = 8'h33;
    rd_reg(8'h01, v); check(v == 8'h33, "R3 cfg after restart", v, 8'h33);

    // R8 standby: freeze, request low, bus alive
    wr_reg(8'h01, 8'h80, 1'b1);
    check(conv_req_o == 1'b0, "R8 conv_req low", conv_req_o, 0);
    v2 = model_temp;
    pulse_temp(8'h11);
    rd_reg(8'h00, v); check(v == v2, "R8 temp frozen", v, v2);
    rd_reg(8'h01, v); check(v == 8'h80, "R8 cfg readable", v, 8'h80);
    wr_reg(8'h01, 8'h00, 1'b1);
    check(conv_req_o == 1'b1, "R8 conv_req back", conv_req_o, 1);
    pulse_temp(8'h22);
    rd_reg(8'h00, v); check(v == 8'h22, "R7 capture resumes", v, 8'h22);

    // R9 master ACK continues, NACK ends transmission
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(v, 1'b1);  check(v == 8'h22, "R9 first byte", v, 8'h22);
    recv_byte(v2, 1'b0); check(v2 == 8'h22, "R9 byte after ack", v2, 8'h22);
    recv_byte(v, 1'b0);  check(v == 8'hFF, "R9 silent after nack", v, 8'hFF);
    bus_stop();

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule